// File: doc/BRIEF.md
# Power-Up Card Identification Reader

This block is a small two-wire bus master. Without any command it reads the identification bytes held in a serial EEPROM on a plug-in card. It starts its work when reset is released. It first waits one bit period with both lines idle. It then signals a start condition and sends a single address byte. It checks that the card acknowledges that byte. After that it clocks in a fixed number of data bytes back to back. It acknowledges every byte except the final one, which tells the EEPROM to stop sending, and it closes the transfer with a stop condition.

Each received byte is handed to a local register file through a one-cycle write strobe, an index and a data byte. A done flag rises when the sequence ends. An error flag marks the case where no device answered the address, which usually means that no card is fitted. Both bus lines are treated as open-drain. The block drives a pull-low enable for each line and reads the real line level back through a synchronizer. This read-back lets a slow device hold the clock low to stretch a bit.

The byte count, the start address and the length of a quarter bit period are parameters. The defaults are sixteen bytes from address zero.

Top module: `card_id_reader`

## Requirements
- R1: After reset is released, with no other input, the block produces exactly one start condition per run: SDA is pulled low while SCL stays released high.
- R2: The address byte sent after the start equals the START_ADDR parameter and goes out most significant bit first. SDA is then released for the ninth clock so the device can acknowledge.
- R3: If SDA reads high during the ninth clock of the address byte, the block issues a stop, sets err and done to 1, and never pulses wr_en.
- R4: Data bits are taken most significant bit first on SCL high. Each complete byte gives one wr_en pulse of exactly one cycle, with wr_data equal to the byte. wr_idx steps 0, 1, … BYTE_COUNT-1 in order.
- R5: During the ninth clock after each data byte, the block pulls SDA low (acknowledge) for every byte except the last. After the last byte it leaves SDA released (no acknowledge).
- R6: The last bus event of a run is a stop: SDA goes from low to high while SCL is released high. After it, both drive-low enables are 0.
- R7: Once done is 1, it stays 1 until the next reset, and no further start condition or line activity occurs.
- R8: While a bit is being transferred, SDA changes only while SCL is pulled low. Changes of SDA with SCL high happen only in the start and stop conditions.
- R9: While rst_n is 0, both drive-low enables, wr_en, done and err are 0. A new reset clears done and err from a finished run and starts a fresh sequence.
- R10: If the block has released SCL but the line still reads low, its bit timing pauses. SCL stays released and SDA does not change until the line is seen high, and the run then completes with correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release launches the read |
| scl_drive_low | output | 1 | 1 pulls the bus clock line low; 0 releases it |
| scl_in | input | 1 | Level read back from the bus clock line |
| sda_drive_low | output | 1 | 1 pulls the bus data line low; 0 releases it |
| sda_in | input | 1 | Level read back from the bus data line |
| wr_en | output | 1 | One-cycle strobe for each received byte |
| wr_idx | output | IDX_W | Register-file index of the byte being written |
| wr_data | output | 8 | Received byte |
| done | output | 1 | Sequence finished (held until reset) |
| err | output | 1 | Address was not acknowledged |

## Verification
The bench builds the reader with QUARTER_CYCLES=2, BYTE_COUNT=5 and START_ADDR=8'hB6. The short quarter period keeps each run to a few hundred cycles, so many complete power-up sequences fit in one run: with a card, without a card, and with a stretched clock. Five bytes give a three-bit index that must step past a power of two, and they place three acknowledged middle bytes between the first byte and the unacknowledged last one. The address 8'hB6 has its top bit set and mixes ones and zeros, so a reversed or shifted bit order in the address phase shows up in the device model.

// File: rtl/cid_pkg.sv
package cid_pkg;

    // Sequencer states; ST_BOOT must stay encoding 0 (reset value).
    typedef enum logic [2:0] {
        ST_BOOT     = 3'd0,
        ST_START    = 3'd1,
        ST_ADDR     = 3'd2,
        ST_ADDR_ACK = 3'd3,
        ST_RD       = 3'd4,
        ST_MACK     = 3'd5,
        ST_STOP     = 3'd6,
        ST_DONE     = 3'd7
    } cid_state_e;

    // Quarter phases of one bit: 0,1 clock low; 2,3 clock high.
    localparam logic [1:0] PH_SAMPLE = 2'd2;
    localparam logic [1:0] PH_LAST   = 2'd3;
    localparam int unsigned BYTE_W   = 8;

endpackage

// File: rtl/cid_sync.sv
module cid_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // Idle bus level is high, so the chain resets to all ones.
    logic [WIDTH-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stg_q[s] <= '1;
            end
        end else begin
            stg_q[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/cid_tick.sv
module cid_tick #(
    parameter int unsigned PERIOD = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);

    if (PERIOD <= 1) begin : g_every
        logic unused_ok;
        assign unused_ok = clk ^ rst_n;
        assign tick      = en;
    end else begin : g_count
        localparam int unsigned CW      = $clog2(PERIOD);
        localparam logic [CW-1:0] TOP   = CW'(PERIOD - 1);

        logic [CW-1:0] cnt_q, cnt_d;

        always_comb begin
            cnt_d = cnt_q;
            if (en) begin
                cnt_d = (cnt_q == TOP) ? '0 : cnt_q + 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_d;
        end

        assign tick = en && (cnt_q == TOP);
    end

endmodule

// File: rtl/cid_shift.sv
module cid_shift #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         shift_in,
    output logic [W-1:0] q
);

    logic [W-1:0] sh_q, sh_d;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d = load_val;
        end else if (shift) begin
            sh_d = {sh_q[W-2:0], shift_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q;

endmodule

// File: rtl/card_id_reader.sv
module card_id_reader #(
    parameter int unsigned QUARTER_CYCLES = 25,
    parameter int unsigned BYTE_COUNT     = 16,
    parameter logic [7:0]  START_ADDR     = 8'h00,
    parameter int unsigned SYNC_STAGES    = 2,
    parameter int unsigned IDX_W          = (BYTE_COUNT > 1) ? $clog2(BYTE_COUNT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             scl_drive_low,
    input  logic             scl_in,
    output logic             sda_drive_low,
    input  logic             sda_in,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic             done,
    output logic             err
);

    import cid_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_COUNT - 1);

    typedef struct packed {
        cid_state_e       st;
        logic [1:0]       phase;
        logic [2:0]       bitcnt;
        logic [IDX_W-1:0] idx;
        logic             nack;
        logic             scl_low;
        logic             sda_low;
        logic             wr_en;
        logic [IDX_W-1:0] wr_idx;
        logic [7:0]       wr_data;
        logic             done;
        logic             err;
    } regs_t;

    regs_t r_q, r_d;

    logic [1:0]        lines_s;
    logic              scl_s, sda_s;
    logic              run_en, tick;
    logic              sh_load, sh_shift;
    logic [BYTE_W-1:0] sh_q;
    logic [1:0]        np;
    logic              at_last, at_sample;
    logic              bit_slot;

    // Line read-back through a synchronizer.
    cid_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_in, sda_in}),
        .q     (lines_s)
    );
    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    // Timing pauses while SCL is released but still seen low (stretching).
    assign run_en = r_q.scl_low || scl_s;

    cid_tick #(.PERIOD(QUARTER_CYCLES)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (run_en),
        .tick  (tick)
    );

    assign at_last   = (r_q.phase == PH_LAST);
    assign at_sample = (r_q.phase == PH_SAMPLE);

    // One register serves outgoing address and incoming data.
    assign sh_load  = tick && at_last && (r_q.st == ST_START);
    assign sh_shift = tick && (((r_q.st == ST_ADDR) && at_last) ||
                               ((r_q.st == ST_RD) && at_sample));

    cid_shift #(.W(BYTE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val (START_ADDR),
        .shift    (sh_shift),
        .shift_in (sda_s),
        .q        (sh_q)
    );

    always_comb begin
        r_d       = r_q;
        r_d.wr_en = 1'b0;
        np        = r_q.phase + 2'd1;

        if (tick) begin
            r_d.phase = np;

            // State sequencing: sample at end of phase 2, advance at end of phase 3.
            unique case (r_q.st)
                ST_BOOT: begin
                    if (at_last) r_d.st = ST_START;
                end
                ST_START: begin
                    if (at_last) begin
                        r_d.st     = ST_ADDR;
                        r_d.bitcnt = 3'd7;
                    end
                end
                ST_ADDR: begin
                    if (at_last) begin
                        if (r_q.bitcnt == 3'd0) r_d.st = ST_ADDR_ACK;
                        else                    r_d.bitcnt = r_q.bitcnt - 3'd1;
                    end
                end
                ST_ADDR_ACK: begin
                    if (at_sample) r_d.nack = sda_s;
                    if (at_last) begin
                        if (r_q.nack) begin
                            r_d.st  = ST_STOP;
                            r_d.err = 1'b1;
                        end else begin
                            r_d.st     = ST_RD;
                            r_d.bitcnt = 3'd7;
                        end
                    end
                end
                ST_RD: begin
                    if (at_last) begin
                        if (r_q.bitcnt == 3'd0) begin
                            r_d.st      = ST_MACK;
                            r_d.wr_en   = 1'b1;
                            r_d.wr_idx  = r_q.idx;
                            r_d.wr_data = sh_q;
                        end else begin
                            r_d.bitcnt = r_q.bitcnt - 3'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (at_last) begin
                        if (r_q.idx == LAST_IDX) begin
                            r_d.st = ST_STOP;
                        end else begin
                            r_d.st     = ST_RD;
                            r_d.bitcnt = 3'd7;
                            r_d.idx    = r_q.idx + 1'b1;
                        end
                    end
                end
                ST_STOP: begin
                    if (at_last) begin
                        r_d.st   = ST_DONE;
                        r_d.done = 1'b1;
                    end
                end
                ST_DONE: begin
                end
            endcase

            // Line levels for the phase being entered. In phase 0 SDA holds
            // its old value, so it moves only once SCL is already low.
            r_d.scl_low = 1'b0;
            unique case (r_d.st)
                ST_BOOT, ST_DONE: begin
                    r_d.sda_low = 1'b0;
                end
                ST_START: begin
                    r_d.sda_low = np[1];
                end
                ST_ADDR: begin
                    r_d.scl_low = ~np[1];
                    if (np != 2'd0) r_d.sda_low = ~sh_q[BYTE_W-1];
                end
                ST_ADDR_ACK, ST_RD: begin
                    r_d.scl_low = ~np[1];
                    if (np != 2'd0) r_d.sda_low = 1'b0;
                end
                ST_MACK: begin
                    r_d.scl_low = ~np[1];
                    if (np != 2'd0) r_d.sda_low = (r_q.idx != LAST_IDX);
                end
                ST_STOP: begin
                    r_d.scl_low = ~np[1];
                    if (np != 2'd0) r_d.sda_low = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bit_slot = (r_q.st == ST_ADDR) || (r_q.st == ST_ADDR_ACK) ||
                      (r_q.st == ST_RD)   || (r_q.st == ST_MACK);

    assign scl_drive_low = r_q.scl_low;
    assign sda_drive_low = r_q.sda_low;
    assign wr_en         = r_q.wr_en;
    assign wr_idx        = r_q.wr_idx;
    assign wr_data       = r_q.wr_data;
    assign done          = r_q.done;
    assign err           = r_q.err;

endmodule

// File: rtl/card_id_reader_chk.sv
module card_id_reader_chk #(
    parameter int unsigned IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_drive_low,
    input logic             sda_drive_low,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic             done,
    input logic             err,
    input logic             bit_slot
);

    logic [IDX_W-1:0] seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     seen_q <= '0;
        else if (wr_en) seen_q <= seen_q + 1'b1;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!scl_drive_low && !sda_drive_low && !wr_en && !done && !err)
                else $error("outputs active during reset"); // R9
        end
    end

    AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_slot && $stable(bit_slot) && !scl_drive_low && $stable(scl_drive_low))
            |-> $stable(sda_drive_low))
        else $error("SDA moved while SCL released in a bit"); // R8

    AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !wr_en)
        else $error("write after address not acknowledged"); // R3

    AST_WR_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx == seen_q))
        else $error("write index out of order"); // R4

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en)
        else $error("write strobe longer than one cycle"); // R4

    AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done)
        else $error("done dropped without reset"); // R7

    AST_DONE_LINES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!scl_drive_low && !sda_drive_low))
        else $error("line driven after done"); // R6

endmodule

bind card_id_reader card_id_reader_chk #(.IDX_W(IDX_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low),
    .wr_en         (wr_en),
    .wr_idx        (wr_idx),
    .done          (done),
    .err           (err),
    .bit_slot      (bit_slot)
);

// File: tb/card_id_reader_bench.sv
module card_id_reader_bench;

    localparam int CLK_PERIOD      = 10;
    localparam int QC              = 2;
    localparam int NBYTES          = 5;
    localparam logic [7:0] SADDR   = 8'hB6;
    localparam int IW              = 3;

    // {card present, data seed}
    localparam logic [8:0] VEC [4] = '{9'h100, 9'h1FF, 9'h06D, 9'h13C};

    logic clk = 1'b0;
    logic rst_n;
    logic scl_drive_low, sda_drive_low, wr_en, done, err;
    logic [IW-1:0] wr_idx;
    logic [7:0] wr_data;

    logic tb_scl_hold = 1'b0;
    logic sl_sda_low  = 1'b0;
    logic sl_present  = 1'b1;
    logic [7:0] sl_seed = 8'h00;

    wire scl_line = !(scl_drive_low || tb_scl_hold);
    wire sda_line = !(sda_drive_low || sl_sda_low);

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    card_id_reader #(
        .QUARTER_CYCLES (QC),
        .BYTE_COUNT     (NBYTES),
        .START_ADDR     (SADDR)
    ) u_card_id_reader (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_drive_low (scl_drive_low),
        .scl_in        (scl_line),
        .sda_drive_low (sda_drive_low),
        .sda_in        (sda_line),
        .wr_en         (wr_en),
        .wr_idx        (wr_idx),
        .wr_data       (wr_data),
        .done          (done),
        .err           (err)
    );

    function automatic logic [7:0] mem_byte(input logic [7:0] seed, input logic [7:0] a);
        logic [7:0] m;
        m = a * 8'd37;
        return (m + seed) ^ 8'h5A;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Bus condition monitors
    event start_ev;
    int start_cnt = 0;
    int stop_cnt  = 0;
    always @(negedge sda_line) if (scl_line === 1'b1) begin start_cnt++; -> start_ev; end
    always @(posedge sda_line) if (scl_line === 1'b1) stop_cnt++;

    // Write capture
    logic [IW-1:0] cap_idx [256];
    logic [7:0]    cap_dat [256];
    int wr_cnt = 0;
    always @(negedge clk) if (wr_en === 1'b1) begin
        cap_idx[wr_cnt % 256] = wr_idx;
        cap_dat[wr_cnt % 256] = wr_data;
        wr_cnt++;
    end

    // EEPROM model
    logic [7:0] sl_rx_addr;
    logic       sl_mack_log [64];
    int         sl_nbytes = 0;
    initial begin
        logic [7:0] a;
        logic [7:0] byte_v;
        forever begin
            @(start_ev);
            sl_nbytes = 0;
            for (int b = 7; b >= 0; b--) begin
                @(posedge scl_line);
                sl_rx_addr[b] = sda_line;
            end
            @(negedge scl_line);
            sl_sda_low = sl_present;
            @(negedge scl_line);
            sl_sda_low = 1'b0;
            if (sl_present) begin
                a = sl_rx_addr;
                for (int k = 0; k < 64; k++) begin
                    byte_v = mem_byte(sl_seed, a);
                    for (int b = 7; b >= 0; b--) begin
                        sl_sda_low = !byte_v[b];
                        @(negedge scl_line);
                    end
                    sl_sda_low = 1'b0;
                    @(posedge scl_line);
                    sl_mack_log[k] = !sda_line;
                    sl_nbytes = k + 1;
                    @(negedge scl_line);
                    if (!sl_mack_log[k]) break;
                    a = a + 8'd1;
                end
            end
        end
    end

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic do_run(input logic present, input logic [7:0] seed, input bit stretch);
        int s0, p0, w0, rises;
        bit ok, stall_ok;
        logic prev, sda_ref;
        sl_present = present;
        sl_seed    = seed;
        s0 = start_cnt; p0 = stop_cnt; w0 = wr_cnt;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!done && !err && !wr_en, "R9 reset clears flags", {done, err, wr_en}, 0);
        rst_n = 1'b1;

        if (stretch) begin
            rises = 0; prev = 1'b0;
            while (rises < 3) begin
                @(negedge clk);
                if (scl_drive_low && !prev) rises++;
                prev = scl_drive_low;
            end
            tb_scl_hold = 1'b1;
            while (scl_drive_low) @(negedge clk);
            sda_ref  = sda_drive_low;
            stall_ok = 1'b1;
            repeat (60) begin
                @(negedge clk);
                if (scl_drive_low || (sda_drive_low != sda_ref) || done) stall_ok = 1'b0;
            end
            tb_scl_hold = 1'b0;
            check(stall_ok, "R10 timing paused while SCL held low", stall_ok, 1);
        end

        wait_done(ok);
        check(ok, "R7 done reached (watchdog)", ok, 1);
        repeat (4) @(negedge clk);

        check(start_cnt - s0 == 1, "R1 one start per run", start_cnt - s0, 1);
        check(sl_rx_addr == SADDR, "R2 address byte", sl_rx_addr, SADDR);
        check(stop_cnt - p0 == 1, "R6 one stop per run", stop_cnt - p0, 1);
        check(scl_line && sda_line && !scl_drive_low && !sda_drive_low,
              "R6 lines released after stop", {scl_drive_low, sda_drive_low}, 0);
        check((start_cnt - s0 == 1) && (stop_cnt - p0 == 1),
              "R8 no stray SDA edge with SCL high", (start_cnt - s0) + (stop_cnt - p0), 2);

        if (present) begin
            check(!err, "R3 no error with card", err, 0);
            check(wr_cnt - w0 == NBYTES, "R4 write count", wr_cnt - w0, NBYTES);
            for (int i = 0; i < NBYTES; i++) begin
                logic [7:0] e;
                e = mem_byte(seed, SADDR + 8'(i));
                check(cap_idx[(w0 + i) % 256] == IW'(i), "R4 write index",
                      cap_idx[(w0 + i) % 256], i);
                check(cap_dat[(w0 + i) % 256] == e, "R4 write data",
                      cap_dat[(w0 + i) % 256], e);
            end
            check(sl_nbytes == NBYTES, "R5 bytes served before no-ack", sl_nbytes, NBYTES);
            for (int k = 0; k < NBYTES; k++) begin
                check(sl_mack_log[k] == (k != NBYTES - 1), "R5 master ack pattern",
                      sl_mack_log[k], (k != NBYTES - 1));
            end
        end else begin
            check(err && done, "R3 error and done without card", {err, done}, 2'b11);
            check(wr_cnt == w0, "R3 no writes without card", wr_cnt - w0, 0);
        end

        repeat (40) @(negedge clk);
        check(done && (start_cnt - s0 == 1) && !scl_drive_low && !sda_drive_low,
              "R7 quiet and done held after finish", {done, scl_drive_low, sda_drive_low}, 3'b100);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b1;
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!scl_drive_low && !sda_drive_low && !wr_en && !done && !err,
              "R9 reset state", {scl_drive_low, sda_drive_low, wr_en, done, err}, 0);

        for (int v = 0; v < 4; v++) begin
            do_run(VEC[v][8], VEC[v][7:0], 1'b0);
        end

        // Directed: stretched clock with a card fitted.
        do_run(1'b1, 8'hC3, 1'b1);

        // Directed: absent card right after a good run, then recovery.
        do_run(1'b0, 8'h00, 1'b0);
        do_run(1'b1, 8'h81, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule